// File: doc/BRIEF.md
# Power and Clock Gating Control Register

This block is one 32-bit control register on a simple synchronous register bus. It holds the chip's low-power settings: a two-bit power-mode selector, a sleep request bit that clears itself, an auto-wake enable, an LED disable, and two clock-disable bits. One clock-disable bit covers a whole timestamp unit and the other covers one of its sub-units. The register's fields drive the sleep request, LED-disable and clock-enable outputs, which go to logic outside this block.

Two kinds of write are guarded. A clock-disable bit sets only on the second of two back-to-back writes of 1 to it. A write that asks for sleep is refused when the same write also changes the power mode, so software must pick the mode first and request sleep in a later write. A sleep request ends at the clock edge after a wake event. A PME event also ends it, but only when auto-wake is enabled.

Top module: `pgc_ctrl_reg`

## Requirements
- R1: After synchronous reset, every field reads 0. In the same state, `sleep_req` and `led_off` are 0, `pm_mode` is 00, and both clock-enable outputs are 1.
- R2: The power mode occupies bits [30:29], and 00 is the fully-on mode. It is loaded by a write to `REG_ADDR` that enables byte lane 3, and it reads back at the same bits.
- R3: A write with bit 28 = 1 whose bits [30:29] equal the current power mode sets the sleep bit. This holds even when the mode is 00. A write with bit 28 = 0 clears the sleep bit.
- R4: A write with bit 28 = 1 whose bits [30:29] differ from the current power mode leaves the sleep bit unchanged. The new power mode is still taken.
- R5: `wake_evt` clears the sleep bit at the next clock edge. If a write arrives in the same cycle, the wake event wins.
- R6: Bit 27 is auto-wake. When it is 1, `pme_evt` clears the sleep bit at the next edge. When it is 0, `pme_evt` has no effect.
- R7: Bit 26 drives `led_off`.
- R8: Bits 25 (whole unit) and 24 (sub-unit) each become 1 only on the second of two consecutive writes of 1 to that bit. A write of 0 clears the bit and cancels a pending first write.
- R9: Some writes change no field and no arming state: a write that leaves byte lane 3 disabled, and a write to any other address.
- R10: `clk_en_unit` is the inverse of bit 25 and `clk_en_sub` is the inverse of bit 24. Both are registered, so each changes one clock after its bit changes.
- R11: A read of `REG_ADDR` returns the fields with bits 31 and 23..0 at 0. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wake_evt | input | 1 | Manual wake event |
| pme_evt | input | 1 | PME event, used for auto-wake |
| sleep_req | output | 1 | Sleep request to the power controller |
| pm_mode | output | 2 | Selected power mode |
| led_off | output | 1 | LED disable |
| clk_en_unit | output | 1 | Clock enable for the whole timestamp unit |
| clk_en_sub | output | 1 | Clock enable for the timestamp sub-unit |

## Verification
A lost or stuck arming flag shows at the ports as a clock-disable bit that is still 0 after the second write of 1, or one that sets after a single write of 1. Either shows in the readback one edge after the write, and on the clock-enable pins one edge after that. A wrong comparison between the old and new power mode shows as a sleep bit that takes or refuses a request in the wrong case. The bench sweeps all sixteen old/new mode pairs to expose this. Wake-priority faults appear as a sleep bit still set on the edge after a wake event.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    localparam int DATA_W     = 32;
    localparam int CTRL_LANE  = 3;
    localparam int PM_LSB     = 29;
    localparam int SLEEP_BIT  = 28;
    localparam int AWAKE_BIT  = 27;
    localparam int LED_BIT    = 26;
    localparam int DIS_LSB    = 24;
    localparam int N_GATES    = 2;

    typedef logic [1:0] pm_t;
    localparam pm_t PM_ON = 2'b00;

    typedef struct packed {
        pm_t                pm;
        logic               sleep;
        logic               awake;
        logic               led;
        logic [N_GATES-1:0] dis;   // [1] whole unit, [0] sub-unit
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[PM_LSB +: 2]        = c.pm;
        v[SLEEP_BIT]          = c.sleep;
        v[AWAKE_BIT]          = c.awake;
        v[LED_BIT]            = c.led;
        v[DIS_LSB +: N_GATES] = c.dis;
        return v;
    endfunction
endpackage

// File: rtl/pgc_sleep_ctl.sv
module pgc_sleep_ctl
    import pgc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lane_wr,
    input  logic wr_sleep,
    input  pm_t  wr_pm,
    input  pm_t  cur_pm,
    input  logic auto_wake,
    input  logic wake_evt,
    input  logic pme_evt,
    output logic sleep_q
);
    logic wake_any;
    logic mode_change;
    logic past_ok;

    assign wake_any    = wake_evt | (pme_evt & auto_wake);
    assign mode_change = (wr_pm != cur_pm);

    always_ff @(posedge clk) begin
        if (rst)             sleep_q <= 1'b0;
        else if (wake_any)   sleep_q <= 1'b0;
        else if (lane_wr) begin
            if (!(wr_sleep && mode_change))
                sleep_q <= wr_sleep;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R5 / R6: a wake ends sleep on the next edge
    a_r5_wake_clears: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(wake_any) |-> !sleep_q);

    // R4: a refused request leaves the sleep bit as it was
    a_r4_reject_keeps: assert property (@(posedge clk) disable iff (rst)
        (lane_wr && wr_sleep && mode_change && !wake_any) |=> (sleep_q == $past(sleep_q)));
endmodule

// File: rtl/pgc_arm_bit.sv
module pgc_arm_bit (
    input  logic clk,
    input  logic rst,
    input  logic lane_wr,
    input  logic wbit,
    output logic dis_q
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (lane_wr) begin
            if (!wbit) begin
                dis_q   <= 1'b0;
                armed_q <= 1'b0;
            end else if (armed_q) begin
                dis_q   <= 1'b1;
                armed_q <= 1'b0;
            end else begin
                armed_q <= 1'b1;
            end
        end
    end

    // R8: the disable bit only rises after an armed state
    a_r8_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(dis_q) |-> $past(armed_q));

    // R9: without a lane write the arming state holds
    a_r9_arm_hold: assert property (@(posedge clk) disable iff (rst)
        !lane_wr |=> $stable(armed_q) && $stable(dis_q));
endmodule

// File: rtl/pgc_gate_en.sv
module pgc_gate_en #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] dis,
    output logic [N-1:0] en_q
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '1;
        else     en_q <= ~dis;
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R10: enables follow the disable bits one edge later
    a_r10_en_lag: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (en_q == ~$past(dis)));
endmodule

// File: rtl/pgc_ctrl_reg.sv
module pgc_ctrl_reg
    import pgc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wake_evt,
    input  logic              pme_evt,
    output logic              sleep_req,
    output logic [1:0]        pm_mode,
    output logic              led_off,
    output logic              clk_en_unit,
    output logic              clk_en_sub
);
    localparam int NBYTES = DATA_W / 8;

    logic               hit;
    logic               lane_wr;
    ctrl_t              cr;
    logic [N_GATES-1:0] dis_bits;
    logic [N_GATES-1:0] en_bits;
    logic [NBYTES-1:0]  be_full;

    assign be_full = bus_be;
    assign hit     = (bus_addr == REG_ADDR);
    assign lane_wr = bus_we && hit && be_full[CTRL_LANE];

    always_ff @(posedge clk) begin
        if (rst) begin
            cr.pm    <= PM_ON;
            cr.awake <= 1'b0;
            cr.led   <= 1'b0;
        end else if (lane_wr) begin
            cr.pm    <= bus_wdata[PM_LSB +: 2];
            cr.awake <= bus_wdata[AWAKE_BIT];
            cr.led   <= bus_wdata[LED_BIT];
        end
    end

    pgc_sleep_ctl u_sleep (
        .clk       (clk),
        .rst       (rst),
        .lane_wr   (lane_wr),
        .wr_sleep  (bus_wdata[SLEEP_BIT]),
        .wr_pm     (bus_wdata[PM_LSB +: 2]),
        .cur_pm    (cr.pm),
        .auto_wake (cr.awake),
        .wake_evt  (wake_evt),
        .pme_evt   (pme_evt),
        .sleep_q   (cr.sleep)
    );

    for (genvar g = 0; g < N_GATES; g++) begin : g_arm
        pgc_arm_bit u_arm (
            .clk     (clk),
            .rst     (rst),
            .lane_wr (lane_wr),
            .wbit    (bus_wdata[DIS_LSB + g]),
            .dis_q   (dis_bits[g])
        );
    end
    assign cr.dis = dis_bits;

    pgc_gate_en #(.N(N_GATES)) u_gate (
        .clk  (clk),
        .rst  (rst),
        .dis  (dis_bits),
        .en_q (en_bits)
    );

    assign bus_rdata   = hit ? pack_ctrl(cr) : '0;
    assign sleep_req   = cr.sleep;
    assign pm_mode     = cr.pm;
    assign led_off     = cr.led;
    assign clk_en_unit = en_bits[1];
    assign clk_en_sub  = en_bits[0];

    // R2 / R9: the mode only moves on a lane write
    a_r2_pm_hold: assert property (@(posedge clk) disable iff (rst)
        !lane_wr |=> $stable(pm_mode) && $stable(led_off));

    // R11: other addresses read as zero
    a_r11_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !hit |-> bus_rdata == 32'h0);
endmodule

// File: tb/pgc_ctrl_reg_tb.sv
module pgc_ctrl_reg_tb_top;
    localparam logic [7:0] A = 8'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wake_evt = 1'b0, pme_evt = 1'b0;
    logic        sleep_req, led_off, clk_en_unit, clk_en_sub;
    logic [1:0]  pm_mode;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    pgc_ctrl_reg #(.ADDR_W(8), .REG_ADDR(A)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_evt(wake_evt),
        .pme_evt(pme_evt), .sleep_req(sleep_req), .pm_mode(pm_mode),
        .led_off(led_off), .clk_en_unit(clk_en_unit), .clk_en_sub(clk_en_sub)
    );

    function automatic logic [31:0] fld(input logic [1:0] pm, input logic s, input logic aw,
                                        input logic led, input logic du, input logic ds);
        return {1'b0, pm, s, aw, led, du, ds, 24'h0};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A; bus_be = '0;
    endtask

    task automatic rd(output logic [31:0] d);
        bus_addr = A;
        #0 d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(r);
        chk("R1 fields", r, 32'h0);
        chk("R1 outs", {27'h0, sleep_req, led_off, pm_mode, clk_en_unit & clk_en_sub}, 32'h1);

        // R11 other address reads zero
        bus_addr = 8'h44; #0;
        chk("R11 miss", bus_rdata, 32'h0);
        bus_addr = A;

        // R2, R3, R4 sweep of old/new mode pairs
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 4; n++) begin
                wr(A, 4'h8, fld(2'(o), 0, 0, 0, 0, 0));
                wr(A, 4'h8, fld(2'(n), 1, 0, 0, 0, 0));
                chk("R2 pm", {30'h0, pm_mode}, 32'(n));
                chk(o == n ? "R3 sleep set" : "R4 sleep refused", {31'h0, sleep_req},
                    {31'h0, o == n});
                wr(A, 4'h8, fld(2'(n), 0, 0, 0, 0, 0));
                chk("R3 sleep clear", {31'h0, sleep_req}, 32'h0);
            end
        end

        // R9 writes without lane 3 or to other address change nothing
        wr(A, 4'h8, fld(2'd2, 0, 0, 1, 0, 0));
        wr(A, 4'h7, 32'hFFFF_FFFF);
        rd(r); chk("R9 lane off", r, fld(2'd2, 0, 0, 1, 0, 0));
        wr(8'h44, 4'hF, 32'hFFFF_FFFF);
        rd(r); chk("R9 other addr", r, fld(2'd2, 0, 0, 1, 0, 0));
        chk("R7 led", {31'h0, led_off}, 32'h1);
        wr(A, 4'h8, fld(2'd2, 0, 0, 0, 0, 0));
        chk("R7 led off", {31'h0, led_off}, 32'h0);

        // R8 arming: all sequences of three writes on each bit
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 8; s++) begin
                logic dis_e, arm_e;
                wr(A, 4'h8, 32'h0);
                dis_e = 0; arm_e = 0;
                for (int k = 0; k < 3; k++) begin
                    logic v;
                    v = s[k];
                    wr(A, 4'h8, 32'(v) << (24 + b));
                    if (!v) begin dis_e = 0; arm_e = 0; end
                    else if (arm_e) begin dis_e = 1; arm_e = 0; end
                    else arm_e = 1;
                    rd(r);
                    chk("R8 arm seq", {31'h0, r[24 + b]}, {31'h0, dis_e});
                    tick();
                    chk("R10 clk en", {31'h0, b ? clk_en_unit : clk_en_sub}, {31'h0, !dis_e});
                end
            end
        end

        // R9 lane-off write between two 1s does not disarm
        wr(A, 4'h8, 32'h0);
        wr(A, 4'h8, 32'h0200_0000);
        wr(A, 4'h7, 32'h0);
        wr(A, 4'h8, 32'h0200_0000);
        rd(r); chk("R9 arm held", {31'h0, r[25]}, 32'h1);
        wr(A, 4'h8, 32'h0);

        // R5 wake clears; wake beats same-cycle write
        wr(A, 4'h8, fld(2'd1, 0, 0, 0, 0, 0));
        wr(A, 4'h8, fld(2'd1, 1, 0, 0, 0, 0));
        chk("R5 pre", {31'h0, sleep_req}, 32'h1);
        @(negedge clk); wake_evt = 1'b1;
        @(negedge clk); wake_evt = 1'b0;
        chk("R5 wake", {31'h0, sleep_req}, 32'h0);
        @(negedge clk);
        wake_evt = 1'b1; bus_we = 1'b1; bus_be = 4'h8; bus_wdata = fld(2'd1, 1, 0, 0, 0, 0);
        @(negedge clk);
        wake_evt = 1'b0; bus_we = 1'b0;
        chk("R5 wake wins", {31'h0, sleep_req}, 32'h0);

        // R6 pme only with auto-wake
        wr(A, 4'h8, fld(2'd3, 0, 0, 0, 0, 0));
        wr(A, 4'h8, fld(2'd3, 1, 0, 0, 0, 0));
        @(negedge clk); pme_evt = 1'b1;
        @(negedge clk); pme_evt = 1'b0;
        chk("R6 pme ignored", {31'h0, sleep_req}, 32'h1);
        wr(A, 4'h8, fld(2'd3, 1, 1, 0, 0, 0));
        @(negedge clk); pme_evt = 1'b1;
        @(negedge clk); pme_evt = 1'b0;
        chk("R6 pme wakes", {31'h0, sleep_req}, 32'h0);
        rd(r); chk("R6 readback", r, fld(2'd3, 0, 1, 0, 0, 0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule